// File: doc/BRIEF.md
# Low-Power Mode Sequencer

The sequencer selects among three operating states of a small microcontroller: full run, a light halt state and a deep sleep state. Sleep and halt requests come from the CPU's instruction decoder. The block drives the primary oscillator enable, the system clock enable and a CPU-idle flag so that each state gets its own clock gating. In halt, the oscillator and the system clock keep running and only the CPU waits. A generic wake input returns the block to run with no reset.

In sleep, the oscillator and the system clock are both gated off. The block then watches five possible wake sources: the external reset pin, a real-time-clock alarm, a debug reset command, a watchdog timeout and a brownout detection. The watchdog source counts only when two configuration bits are set: the watchdog runs from the always-on low-frequency clock, and it is set to reset on timeout. The brownout source counts only when brownout detection is enabled.

Leaving sleep is always a full reset. The block re-enables the oscillator and holds the system reset low for a settling delay of `DELAY_CYCLES` ticks of the always-on clock. It raises the system clock enable one cycle before it releases the reset. The whole block runs on the always-on clock.

Top module: `lpm_sequencer`

## Requirements
- R1: After `rst_n` is released, and in every RUN cycle, `mode_o` is RUN, `osc_en`=1, `sysclk_en`=1, `cpu_idle`=0 and `sys_rst_n`=1.
- R2: In RUN, `sleep_req`=1 moves the block to SLEEP in the next cycle. In SLEEP, `osc_en`=0, `sysclk_en`=0, `cpu_idle`=1 and `sys_rst_n`=1.
- R3: In RUN, `halt_req`=1 with `sleep_req`=0 moves the block to HALT in the next cycle. In HALT, `osc_en`=1, `sysclk_en`=1, `cpu_idle`=1 and `sys_rst_n`=1.
- R4: When `sleep_req` and `halt_req` are both high in a RUN cycle, the block enters SLEEP.
- R5: `sleep_req` and `halt_req` have no effect in any state other than RUN.
- R6: In HALT, `wake_i`=1 returns the block to RUN in the next cycle, and `sys_rst_n` stays high. The sleep wake sources have no effect in HALT. `wake_i` has no effect in SLEEP.
- R7: In SLEEP, any of `ext_rst_n`=0, `rtc_alarm`=1 or `dbg_rst`=1 moves the block to RESET_DELAY in the next cycle.
- R8: In SLEEP, `wdt_timeout`=1 wakes the block only when `cfg_wdt_lfclk`=1 and `cfg_wdt_rst_en`=1. With either bit at 0, the block stays in SLEEP.
- R9: In SLEEP, `bod_detect`=1 wakes the block only when `cfg_bod_en`=1.
- R10: RESET_DELAY lasts exactly `DELAY_CYCLES` cycles, and the block then enters RUN. Throughout RESET_DELAY, `sys_rst_n`=0, `osc_en`=1 and `cpu_idle`=1.
- R11: In RESET_DELAY, `sysclk_en` is 1 only in the last cycle, so it rises one cycle before `sys_rst_n` rises.
- R12: `mode_o` encodes the state as RUN=0, HALT=1, SLEEP=2, RESET_DELAY=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sleep_req | input | 1 | Deep-sleep request from the instruction decoder |
| halt_req | input | 1 | Halt request from the instruction decoder |
| wake_i | input | 1 | Generic wake (interrupt) for leaving halt |
| ext_rst_n | input | 1 | External reset pin, active low |
| rtc_alarm | input | 1 | Real-time-clock alarm flag |
| dbg_rst | input | 1 | Debug reset command flag |
| wdt_timeout | input | 1 | Watchdog timeout flag |
| bod_detect | input | 1 | Brownout detection flag |
| cfg_wdt_lfclk | input | 1 | Watchdog runs from the always-on clock |
| cfg_wdt_rst_en | input | 1 | Watchdog timeout causes a reset |
| cfg_bod_en | input | 1 | Brownout detection enabled |
| osc_en | output | 1 | Primary oscillator enable |
| sysclk_en | output | 1 | System clock enable |
| cpu_idle | output | 1 | CPU held idle, program counter frozen |
| sys_rst_n | output | 1 | System reset, active low |
| mode_o | output | 2 | Current state code |

## Verification
All outputs are decoded from the registered state and the delay count. A request or wake event sampled at one clock edge therefore shows on `mode_o` and the enables right after that same edge. The bench drives its inputs just after an edge and compares the outputs 2 ns after the following edge. Leaving the delay needs `DELAY_CYCLES` edges after the wake edge. `sysclk_en` rises after edge `DELAY_CYCLES`-1 and `sys_rst_n` rises after edge `DELAY_CYCLES`, so the bench counts the cycles with reset low and notes the clock enable in the cycle just before the release. A cycle-accurate model of the four states, driven from the requirements, predicts every output on every cycle of the random phase.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes a 2-bit state code that is also visible on the mode output.
package lpm_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_DELAY = 2'd3
    } lpm_state_e;
endpackage

// File: rtl/lpm_wake_qual.sv
// Combines the sleep wake sources into a single flag. Each source is qualified
// by its configuration bits. Assumes all inputs are already synchronous to clk.
module lpm_wake_qual (
    input  logic ext_rst_n,
    input  logic rtc_alarm,
    input  logic dbg_rst,
    input  logic wdt_timeout,
    input  logic bod_detect,
    input  logic cfg_wdt_lfclk,
    input  logic cfg_wdt_rst_en,
    input  logic cfg_bod_en,
    output logic wake_any
);
    logic wdt_ok;
    logic bod_ok;

    // Purpose: a watchdog wake needs the always-on clock source and the reset action.
    always_comb wdt_ok = wdt_timeout & cfg_wdt_lfclk & cfg_wdt_rst_en;

    // Purpose: a brownout wake needs the detector to be enabled.
    always_comb bod_ok = bod_detect & cfg_bod_en;

    // Purpose: OR together all the qualified wake sources.
    always_comb wake_any = ~ext_rst_n | rtc_alarm | dbg_rst | wdt_ok | bod_ok;
endmodule

// File: rtl/lpm_delay_cnt.sv
// Settling-delay counter. It counts while enabled and clears otherwise.
// done is high during the last of DELAY_CYCLES enabled cycles.
// Assumes DELAY_CYCLES >= 2.
module lpm_delay_cnt #(
    parameter int DELAY_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic done
);
    localparam int CW = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: advance the count in the delay state and wrap to zero at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_en || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: flag the final delay cycle.
    always_comb done = run_en && (cnt_q == LAST);
endmodule

// File: rtl/lpm_fsm.sv
// Four-state power-mode controller. Requests are accepted only in RUN, and
// sleep wins over halt. Every sleep exit passes through the delay state.
// Assumes wake_any is already qualified.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       halt_req,
    input  logic       wake_i,
    input  logic       wake_any,
    input  logic       delay_done,
    output lpm_state_e state
);
    lpm_state_e state_q;
    lpm_state_e state_d;

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN: begin
                if (sleep_req)     state_d = ST_SLEEP;
                else if (halt_req) state_d = ST_HALT;
            end
            ST_HALT:  if (wake_i)     state_d = ST_RUN;
            ST_SLEEP: if (wake_any)   state_d = ST_DELAY;
            ST_DELAY: if (delay_done) state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    // Purpose: state register, reset to RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb state = state_q;
endmodule

// File: rtl/lpm_sequencer.sv
// Low-power mode sequencer top. It connects the wake qualifier, the settling
// counter and the state machine, and decodes the gating outputs from state.
// Assumes a single always-on clock and a synchronous active-low reset.
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int DELAY_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       halt_req,
    input  logic       wake_i,
    input  logic       ext_rst_n,
    input  logic       rtc_alarm,
    input  logic       dbg_rst,
    input  logic       wdt_timeout,
    input  logic       bod_detect,
    input  logic       cfg_wdt_lfclk,
    input  logic       cfg_wdt_rst_en,
    input  logic       cfg_bod_en,
    output logic       osc_en,
    output logic       sysclk_en,
    output logic       cpu_idle,
    output logic       sys_rst_n,
    output logic [1:0] mode_o
);
    lpm_state_e state;
    logic       wake_any;
    logic       delay_done;
    logic       in_delay;

    lpm_wake_qual u_wake (
        .ext_rst_n      (ext_rst_n),
        .rtc_alarm      (rtc_alarm),
        .dbg_rst        (dbg_rst),
        .wdt_timeout    (wdt_timeout),
        .bod_detect     (bod_detect),
        .cfg_wdt_lfclk  (cfg_wdt_lfclk),
        .cfg_wdt_rst_en (cfg_wdt_rst_en),
        .cfg_bod_en     (cfg_bod_en),
        .wake_any       (wake_any)
    );

    // Purpose: the counter runs only in the delay state.
    always_comb in_delay = (state == ST_DELAY);

    lpm_delay_cnt #(.DELAY_CYCLES(DELAY_CYCLES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (in_delay),
        .done   (delay_done)
    );

    lpm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .halt_req   (halt_req),
        .wake_i     (wake_i),
        .wake_any   (wake_any),
        .delay_done (delay_done),
        .state      (state)
    );

    // Purpose: decode the clock gating, idle and reset outputs from the state.
    always_comb begin
        osc_en    = 1'b1;
        sysclk_en = 1'b1;
        cpu_idle  = 1'b0;
        sys_rst_n = 1'b1;
        case (state)
            ST_HALT: cpu_idle = 1'b1;
            ST_SLEEP: begin
                osc_en    = 1'b0;
                sysclk_en = 1'b0;
                cpu_idle  = 1'b1;
            end
            ST_DELAY: begin
                sysclk_en = delay_done;
                cpu_idle  = 1'b1;
                sys_rst_n = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb mode_o = state;
endmodule

// File: rtl/lpm_checker.sv
// Property checker for the low-power mode sequencer, bound to the top.
// Keeps its own count of delay cycles to check the settling window length.
module lpm_checker #(
    parameter int DELAY_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       halt_req,
    input logic       wake_i,
    input logic       ext_rst_n,
    input logic       rtc_alarm,
    input logic       dbg_rst,
    input logic       wdt_timeout,
    input logic       bod_detect,
    input logic       cfg_wdt_lfclk,
    input logic       cfg_wdt_rst_en,
    input logic       cfg_bod_en,
    input logic       osc_en,
    input logic       sysclk_en,
    input logic       cpu_idle,
    input logic       sys_rst_n,
    input logic [1:0] mode_o
);
    localparam logic [1:0] M_RUN = 2'd0, M_HALT = 2'd1, M_SLEEP = 2'd2, M_DELAY = 2'd3;

    int  dcnt;
    logic no_wake;

    // Purpose: count cycles spent in the delay state.
    always_ff @(posedge clk) begin
        if (!rst_n)                dcnt <= 0;
        else if (mode_o == M_DELAY) dcnt <= dcnt + 1;
        else                        dcnt <= 0;
    end

    // Purpose: true when no sleep wake source qualifies.
    always_comb no_wake = ext_rst_n && !rtc_alarm && !dbg_rst
                          && !(wdt_timeout && cfg_wdt_lfclk && cfg_wdt_rst_en)
                          && !(bod_detect && cfg_bod_en);

    // R2
    sleep_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SLEEP) |-> (!osc_en && !sysclk_en && cpu_idle && sys_rst_n));

    // R3
    halt_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_HALT) |-> (osc_en && sysclk_en && cpu_idle));

    // R4
    sleep_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_RUN && sleep_req && halt_req) |=> (mode_o == M_SLEEP));

    // R6
    halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_HALT && wake_i) |=> (mode_o == M_RUN && sys_rst_n));

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SLEEP && no_wake) |=> (mode_o == M_SLEEP));

    // R7
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SLEEP && !no_wake) |=> (mode_o == M_DELAY && !sys_rst_n));

    // R10
    delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_DELAY && dcnt < DELAY_CYCLES - 1) |=> (mode_o == M_DELAY));

    // R10
    delay_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_DELAY && dcnt == DELAY_CYCLES - 1) |=> (mode_o == M_RUN));

    // R11
    clk_before_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(sysclk_en));
endmodule

bind lpm_sequencer lpm_checker #(.DELAY_CYCLES(DELAY_CYCLES)) u_lpm_chk (.*);

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
    localparam int N = 24;
    localparam int S_RUN = 0, S_HALT = 1, S_SLEEP = 2, S_DELAY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, halt_req = 0, wake_i = 0, ext_rst_n = 1, rtc_alarm = 0;
    logic dbg_rst = 0, wdt_timeout = 0, bod_detect = 0;
    logic cfg_wdt_lfclk = 0, cfg_wdt_rst_en = 0, cfg_bod_en = 0;
    logic osc_en, sysclk_en, cpu_idle, sys_rst_n;
    logic [1:0] mode_o;

    int checks = 0;
    int errors = 0;
    int ms = S_RUN;
    int mc = 0;

    always #5 clk = ~clk;

    lpm_sequencer #(.DELAY_CYCLES(N)) dut (.*);

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit wake_ok();
        return !ext_rst_n || rtc_alarm || dbg_rst
               || (wdt_timeout && cfg_wdt_lfclk && cfg_wdt_rst_en)
               || (bod_detect && cfg_bod_en);
    endfunction

    task automatic quiet();
        sleep_req = 0; halt_req = 0; wake_i = 0; ext_rst_n = 1;
        rtc_alarm = 0; dbg_rst = 0; wdt_timeout = 0; bod_detect = 0;
    endtask

    // Compare every output with the model state
    task automatic compare();
        string t;
        chk("R12", "mode_o", int'(mode_o), ms);
        case (ms)
            S_RUN:   t = "R1";
            S_HALT:  t = "R3";
            S_SLEEP: t = "R2";
            default: t = "R10";
        endcase
        chk(t, "osc_en", int'(osc_en), (ms == S_SLEEP) ? 0 : 1);
        chk(t, "cpu_idle", int'(cpu_idle), (ms == S_RUN) ? 0 : 1);
        chk(t, "sys_rst_n", int'(sys_rst_n), (ms == S_DELAY) ? 0 : 1);
        chk((ms == S_DELAY) ? "R11" : t, "sysclk_en", int'(sysclk_en),
            (ms == S_SLEEP) ? 0 : (ms == S_DELAY) ? ((mc == N - 1) ? 1 : 0) : 1);
    endtask

    // One clock: model next state from current inputs, then check after the edge
    task automatic step();
        int ns = ms;
        int nc = 0;
        case (ms)
            S_RUN:   if (sleep_req) ns = S_SLEEP; else if (halt_req) ns = S_HALT;
            S_HALT:  if (wake_i) ns = S_RUN;
            S_SLEEP: if (wake_ok()) ns = S_DELAY;
            default: begin
                if (mc == N - 1) ns = S_RUN;
                else nc = mc + 1;
            end
        endcase
        @(posedge clk);
        ms = ns;
        mc = nc;
        #2;
        compare();
    endtask

    task automatic go_sleep();
        quiet(); sleep_req = 1; step(); quiet();
    endtask

    task automatic drain_delay();
        quiet();
        for (int i = 0; i < N + 2 && ms != S_RUN; i++) step();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        step();
        chk("R1", "reset mode", int'(mode_o), S_RUN);

        // R4: both requests together
        sleep_req = 1; halt_req = 1; step(); quiet();
        chk("R4", "sleep wins", int'(mode_o), S_SLEEP);
        // R5 and R6: requests and wake_i ignored in SLEEP
        sleep_req = 1; halt_req = 1; wake_i = 1; step(); quiet();
        chk("R5", "req in sleep", int'(mode_o), S_SLEEP);
        // R8: watchdog qualification
        wdt_timeout = 1; cfg_wdt_lfclk = 1; cfg_wdt_rst_en = 0; step();
        chk("R8", "wdt no rst_en", int'(mode_o), S_SLEEP);
        cfg_wdt_lfclk = 0; cfg_wdt_rst_en = 1; step();
        chk("R8", "wdt no lfclk", int'(mode_o), S_SLEEP);
        cfg_wdt_lfclk = 1; step(); quiet();
        chk("R8", "wdt qualified", int'(mode_o), S_DELAY);
        begin
            int low = 1;
            int clk_pre = 0;
            while (ms != S_RUN && low < N + 4) begin
                clk_pre = int'(sysclk_en);
                step();
                if (!sys_rst_n) low++;
            end
            chk("R10", "reset low cycles", low, N);
            chk("R11", "sysclk before release", clk_pre, 1);
            chk("R10", "back to run", int'(mode_o), S_RUN);
        end

        // R3 and R6: halt and its exit
        halt_req = 1; step(); quiet();
        chk("R3", "enter halt", int'(mode_o), S_HALT);
        rtc_alarm = 1; ext_rst_n = 0; sleep_req = 1; step(); quiet();
        chk("R6", "sleep sources in halt", int'(mode_o), S_HALT);
        wake_i = 1; step(); quiet();
        chk("R6", "halt exit", int'(mode_o), S_RUN);
        chk("R6", "no reset on halt exit", int'(sys_rst_n), 1);

        // R9: brownout qualification
        go_sleep();
        cfg_bod_en = 0; bod_detect = 1; step();
        chk("R9", "bod disabled", int'(mode_o), S_SLEEP);
        cfg_bod_en = 1; step();
        chk("R9", "bod enabled", int'(mode_o), S_DELAY);
        drain_delay();

        // R7: the unconditional sources
        for (int k = 0; k < 3; k++) begin
            go_sleep();
            if (k == 0) ext_rst_n = 0;
            if (k == 1) rtc_alarm = 1;
            if (k == 2) dbg_rst = 1;
            step();
            chk("R7", "wake source", int'(mode_o), S_DELAY);
            drain_delay();
        end

        // Random phase, checked each cycle against the model
        for (int i = 0; i < 4000; i++) begin
            sleep_req      = ($urandom % 8) == 0;
            halt_req       = ($urandom % 6) == 0;
            wake_i         = ($urandom % 4) == 0;
            ext_rst_n      = ($urandom % 40) != 0;
            rtc_alarm      = ($urandom % 40) == 0;
            dbg_rst        = ($urandom % 40) == 0;
            wdt_timeout    = ($urandom % 8) == 0;
            bod_detect     = ($urandom % 8) == 0;
            cfg_wdt_lfclk  = $urandom % 2;
            cfg_wdt_rst_en = $urandom % 2;
            cfg_bod_en     = $urandom % 2;
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule